// File: doc/BRIEF.md
# Composite-Field GF(4096) Multiplier

This block multiplies two 12-bit elements of GF(4096). The field is built in two levels. The lower level is GF(64), reduced by x^6+x+1. The upper level extends it by x^2+x+A^-1, where A generates GF(64). Each operand is split into a 6-bit upper half and a 6-bit lower half. The two halves of the product come from three GF(64) products and one multiplication by the GF(64) constant 0x21. The path from operands to product is combinational, and one output register sits at its end.

A second mode walks through the powers of the field generator 0xE01. In this mode the block takes the value on `a_i` and returns the next element of the sequence. A zero input returns 1, which starts the walk. Any other input is multiplied by 0xE01. To step through the powers one after another, the caller feeds each result back into `a_i`. Every accepted request gives its result exactly one cycle later.

Top module: `gf4096_tower_mul`

## Requirements
- R1: While `rst_ni` is low and after it is released, `valid_o` is 0 and `prod_o` is 0x000 until the first accepted request.
- R2: When `valid_i` is 1 at a rising edge, `valid_o` is 1 after that edge. When `valid_i` is 0 at a rising edge, `valid_o` is 0 after that edge.
- R3: A rising edge with `valid_i` low leaves `prod_o` unchanged.
- R4: Multiply mode is `mode_i` = 0. In this mode, a zero in either operand gives a product of 0x000.
- R5: In multiply mode, an operand equal to 0x001 gives the other operand unchanged as the product.
- R6: In multiply mode, the product is (H<<6)^L. Here ah, bh are bits 11:6 and al, bl are bits 5:0 of the operands. H = m(ah^al, bh^bl) ^ m(al,bl) and L = m(m(ah,bh), 0x21) ^ m(al,bl). m is GF(64) multiplication modulo x^6+x+1, which means XOR with 0x43 whenever bit 6 is set.
- R7: In multiply mode, swapping `a_i` and `b_i` gives the same product.
- R8: Step mode is `mode_i` = 1. In this mode, `a_i` = 0x000 gives 0x001 whatever `b_i` holds.
- R9: In step mode, a nonzero `a_i` gives `a_i` multiplied by 0xE01 by the rule of R6, and `b_i` has no effect.
- R10: Start at 0x001 and feed each step-mode result back as the next input. The sequence returns to 0x001 after exactly 4095 steps and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request accepted at this edge |
| mode_i | input | 1 | 0 = multiply `a_i` by `b_i`, 1 = step `a_i` by the generator |
| a_i | input | 12 | First operand, or the current sequence element |
| b_i | input | 12 | Second operand (ignored in step mode) |
| valid_o | output | 1 | Result on `prod_o` is new this cycle |
| prod_o | output | 12 | Registered result |

## Verification
The hardest case to reach from the ports is the full period of the generator. It needs 4095 dependent requests in a row, and each one must take the previous registered output as its input. Any error in the reduction constant, the extension constant or the half split would shorten or break the cycle. The bench keeps the chain going by copying `prod_o` back into `a_i` on every step. It also watches every intermediate value for an early return to 0x001. Products with operands that are nonzero only in the upper half reach the constant-multiplier path, which the identity cases never touch. These products are checked against hand-computed values.

// File: rtl/gf_tower_pkg.sv
package gf_tower_pkg;
  localparam int unsigned SUB_W_DEF     = 6;
  localparam logic [6:0]  BASE_POLY_DEF = 7'h43;
  localparam logic [5:0]  EXT_CONST_DEF = 6'h21;
  localparam logic [11:0] GEN_DEF       = 12'hE01;

  typedef enum logic {
    OP_MUL  = 1'b0,
    OP_STEP = 1'b1
  } gf_op_e;
endpackage

// File: rtl/gf_sub_mul.sv
// Shift-and-add multiplier over GF(2^W), one generate stage per operand bit.
module gf_sub_mul #(
  parameter int unsigned W    = 6,
  parameter logic [W:0]  POLY = 7'h43
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] p_o
);
  logic [W-1:0] acc [W+1];
  logic [W-1:0] sh  [W];

  assign acc[0] = '0;
  assign sh[0]  = b_i;

  for (genvar i = 0; i < W; i++) begin : g_stage
    assign acc[i+1] = a_i[i] ? (acc[i] ^ sh[i]) : acc[i];
    if (i < W - 1) begin : g_shift
      logic [W:0] dbl;
      assign dbl     = {sh[i], 1'b0};
      assign sh[i+1] = dbl[W] ? (dbl[W-1:0] ^ POLY[W-1:0]) : dbl[W-1:0];
    end
  end

  assign p_o = acc[W];
endmodule

// File: rtl/gf_tower_core.sv
// Quadratic extension over GF(2^W): three base products plus one constant product.
module gf_tower_core #(
  parameter int unsigned W         = 6,
  parameter logic [W:0]  POLY      = 7'h43,
  parameter logic [W-1:0] EXT_CONST = 6'h21,
  localparam int unsigned FW       = 2 * W
) (
  input  logic [FW-1:0] a_i,
  input  logic [FW-1:0] b_i,
  output logic [FW-1:0] p_o
);
  logic [W-1:0] ah, al, bh, bl;
  logic [W-1:0] sum_p, low_p, high_p, cst_p;

  assign ah = a_i[FW-1:W];
  assign al = a_i[W-1:0];
  assign bh = b_i[FW-1:W];
  assign bl = b_i[W-1:0];

  gf_sub_mul #(.W(W), .POLY(POLY)) u_sum (.a_i(ah ^ al), .b_i(bh ^ bl), .p_o(sum_p));
  gf_sub_mul #(.W(W), .POLY(POLY)) u_low (.a_i(al), .b_i(bl), .p_o(low_p));
  gf_sub_mul #(.W(W), .POLY(POLY)) u_high (.a_i(ah), .b_i(bh), .p_o(high_p));
  gf_sub_mul #(.W(W), .POLY(POLY)) u_cst (.a_i(high_p), .b_i(EXT_CONST), .p_o(cst_p));

  assign p_o = {sum_p ^ low_p, cst_p ^ low_p};
endmodule

// File: rtl/gf4096_tower_mul.sv
module gf4096_tower_mul
  import gf_tower_pkg::*;
#(
  parameter int unsigned SUB_W     = SUB_W_DEF,
  parameter logic [SUB_W:0]     BASE_POLY = BASE_POLY_DEF,
  parameter logic [SUB_W-1:0]   EXT_CONST = EXT_CONST_DEF,
  parameter logic [2*SUB_W-1:0] GEN       = GEN_DEF
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 valid_i,
  input  logic                 mode_i,
  input  logic [2*SUB_W-1:0]   a_i,
  input  logic [2*SUB_W-1:0]   b_i,
  output logic                 valid_o,
  output logic [2*SUB_W-1:0]   prod_o
);
  localparam int unsigned FULL_W = 2 * SUB_W;
  localparam logic [FULL_W-1:0] ONE = FULL_W'(1);

  gf_op_e            op;
  logic              step;
  logic [FULL_W-1:0] opnd_b, core_p, nxt;
  logic              valid_q;
  logic [FULL_W-1:0] prod_q;

  assign op     = gf_op_e'(mode_i);
  assign step   = (op == OP_STEP);
  assign opnd_b = step ? GEN : b_i;

  gf_tower_core #(.W(SUB_W), .POLY(BASE_POLY), .EXT_CONST(EXT_CONST)) u_core (
    .a_i(a_i), .b_i(opnd_b), .p_o(core_p)
  );

  // step mode seeds the power walk with 1 on a zero input
  assign nxt = (step && (a_i == '0)) ? ONE : core_p;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      prod_q  <= '0;
    end else begin
      valid_q <= valid_i;
      if (valid_i) prod_q <= nxt;
    end
  end

  assign valid_o = valid_q;
  assign prod_o  = prod_q;

  a_r2_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  a_r2_idle_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  a_r3_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(prod_o));
  a_r4_zero_operand: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !mode_i && (a_i == '0 || b_i == '0)) |=> (prod_o == '0));
  a_r5_identity: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !mode_i && b_i == ONE) |=> (prod_o == $past(a_i)));
  a_r8_step_seed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mode_i && a_i == '0) |=> (prod_o == ONE));
endmodule

// File: tb/gf4096_tower_mul_tb_top.sv
`timescale 1ns/1ps
module gf4096_tower_mul_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic        mode_i = 1'b0;
  logic [11:0] a_i = '0;
  logic [11:0] b_i = '0;
  logic        valid_o;
  logic [11:0] prod_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  gf4096_tower_mul dut_i (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .mode_i(mode_i),
    .a_i(a_i), .b_i(b_i), .valid_o(valid_o), .prod_o(prod_o)
  );

  typedef struct packed {
    logic        mode;
    logic [11:0] a;
    logic [11:0] b;
    logic [11:0] exp;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 12'h000, 12'h5A3, 12'h000},  // R4
    '{1'b0, 12'hABC, 12'h000, 12'h000},  // R4
    '{1'b0, 12'h7E5, 12'h001, 12'h7E5},  // R5
    '{1'b0, 12'h001, 12'h3C9, 12'h3C9},  // R5
    '{1'b0, 12'h002, 12'h020, 12'h003},  // R6 base reduction
    '{1'b0, 12'h040, 12'h040, 12'h061},  // R6 extension constant
    '{1'b0, 12'h040, 12'h002, 12'h080},  // R6 mixed halves
    '{1'b1, 12'h000, 12'h123, 12'h001},  // R8
    '{1'b1, 12'h001, 12'hFFF, 12'hE01}   // R9
  };

  function automatic logic [5:0] ref_m64(input logic [5:0] x, input logic [5:0] y);
    logic [10:0] p;
    p = '0;
    for (int i = 0; i < 6; i++) if (y[i]) p ^= 11'(x) << i;
    for (int k = 10; k >= 6; k--) if (p[k]) p ^= 11'h43 << (k - 6);
    return p[5:0];
  endfunction

  function automatic logic [11:0] ref_mul(input logic [11:0] x, input logic [11:0] y);
    logic [5:0] hi, lo, ll;
    ll = ref_m64(x[5:0], y[5:0]);
    hi = ref_m64(x[11:6] ^ x[5:0], y[11:6] ^ y[5:0]) ^ ll;
    lo = ref_m64(ref_m64(x[11:6], y[11:6]), 6'h21) ^ ll;
    return {hi, lo};
  endfunction

  task automatic chk(input string req, input logic [11:0] act, input logic [11:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%03h expected 0x%03h", req, act, exp);
    end
  endtask

  // one request; returns the registered result sampled away from the edge
  task automatic run_op(input logic m, input logic [11:0] a, input logic [11:0] b,
                        output logic [11:0] r, output logic v);
    @(negedge clk);
    valid_i = 1'b1; mode_i = m; a_i = a; b_i = b;
    @(negedge clk);
    valid_i = 1'b0;
    r = prod_o;
    v = valid_o;
  endtask

  initial begin
    logic [11:0] r, r2, held;
    logic        v;
    logic        early;
    logic [11:0] cur;

    repeat (3) @(negedge clk);
    chk("R1 valid in reset", 12'(valid_o), 12'h0);
    chk("R1 result in reset", prod_o, 12'h000);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 valid after reset", 12'(valid_o), 12'h0);
    chk("R1 result after reset", prod_o, 12'h000);

    for (int i = 0; i < NV; i++) begin
      run_op(VEC[i].mode, VEC[i].a, VEC[i].b, r, v);
      chk($sformatf("table row %0d (R4 R5 R6 R8 R9)", i), r, VEC[i].exp);
      chk("R2 valid one cycle after request", 12'(v), 12'h1);
    end

    // R2, R3: idle cycle drops valid and holds result
    run_op(1'b0, 12'h9D7, 12'h4E2, held, v);
    @(negedge clk);
    chk("R2 valid drops when idle", 12'(valid_o), 12'h0);
    a_i = 12'h111; b_i = 12'h222;
    @(negedge clk);
    chk("R3 result held when idle", prod_o, held);

    // R6, R7: random operands against model and with operands swapped
    for (int i = 0; i < 150; i++) begin
      logic [11:0] x, y;
      x = 12'($urandom);
      y = 12'($urandom);
      run_op(1'b0, x, y, r, v);
      run_op(1'b0, y, x, r2, v);
      chk("R6 product vs model", r, ref_mul(x, y));
      chk("R7 commutative", r2, r);
    end

    // R9: b_i ignored in step mode
    run_op(1'b1, 12'h5A3, 12'h000, r, v);
    run_op(1'b1, 12'h5A3, 12'hFFF, r2, v);
    chk("R9 step vs model", r, ref_mul(12'h5A3, 12'hE01));
    chk("R9 b_i ignored in step", r2, r);

    // R10: full generator period
    run_op(1'b1, 12'h000, 12'h000, cur, v);
    chk("R10 seed", cur, 12'h001);
    early = 1'b0;
    for (int s = 1; s <= 4095; s++) begin
      run_op(1'b1, cur, 12'hABC, cur, v);
      if (s < 4095 && cur == 12'h001) early = 1'b1;
    end
    chk("R10 no early return to 1", 12'(early), 12'h0);
    chk("R10 back to 1 after 4095 steps", cur, 12'h001);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule